// File: doc/BRIEF.md
# Power-stage gate drive controller

This block is the digital sequencing logic placed in front of a synchronous buck power stage. Each clock it samples a digitized three-level PWM command, a digitized three-level enable line and two undervoltage comparator flags. From them it derives complementary high-side and low-side gate enables, an enable for the internal logic regulator and a two-bit mode report. The gate outputs pass through an overlap guard. That guard inserts a programmable number of idle cycles before either gate is switched on.

A PWM line that floats or sticks between the thresholds reads as the mid level. If that level persists for a programmable hold-off count, the block latches both gates off. Only a clean high level on the PWM line releases the latch. Supply undervoltage lockout uses two separate comparator flags, which gives it hysteresis. Lockout removes the regulator enable as well as the gates. The enable line stops only gate switching and leaves the regulator running.

Top module: `gate_drive_ctrl`

## Requirements
- R1: With `pwm_lvl` = 2'b10 (high) and the block active, `hs_gate` becomes 1 and `ls_gate` 0. With `pwm_lvl` = 2'b00 (low), `ls_gate` becomes 1 and `hs_gate` 0. A mid sample (2'b01, or the unused code 2'b11) keeps the last high/low choice.
- R2: Mid samples on `pwm_lvl` on HOLDOFF_CYCLES consecutive rising edges enter the float shutdown: mode 2'b10, both gates 0. Any high or low sample restarts the count, so a mid run one sample shorter causes no shutdown.
- R3: Once in float shutdown, only a high PWM sample leaves it. Low samples and further mid samples keep it.
- R4: `en_lvl` = 2'b10 permits switching. The codes 2'b00 (driven low), 2'b01 (open) and 2'b11 give mode 2'b01 with both gates 0, while `reg_en` stays 1.
- R5: Lockout ends only on an edge where `uv_start` = 1 and `uv_stop` = 0. Out of lockout, the block returns to lockout only on an edge where `uv_stop` = 1. With both flags set during lockout, lockout continues.
- R6: During lockout (mode 2'b00) both gates and `reg_en` are 0.
- R7: `hs_gate` and `ls_gate` are never both 1. Either gate turns on only after both gates have been 0 for at least DEAD_CYCLES clock periods.
- R8: `mode` reports 2'b00 lockout, 2'b01 disabled, 2'b10 float shutdown and 2'b11 active, in that order of priority.
- R9: While `rst_n` is 0, all outputs are 0 at once, without waiting for a clock edge. After release the block starts in lockout.
- R10: `mode` and `reg_en` reflect an input one edge after it is sampled. Gates fall one edge after mode leaves 2'b11. A gate rises no sooner than DEAD_CYCLES edges after the other gate fell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_lvl | input | 2 | PWM command level: 00 low, 01 mid, 10 high, 11 treated as mid |
| en_lvl | input | 2 | Enable line level: 00 low, 01 open, 10 high, 11 treated as open |
| uv_start | input | 1 | Supply is above the start threshold |
| uv_stop | input | 1 | Supply is below the stop threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| reg_en | output | 1 | Internal logic regulator enable |
| mode | output | 2 | Current operating mode |

## Verification
Mode and regulator enable are due one rising edge after the sampled input. A gate falls one edge after the mode leaves active. A gate rises DEAD_CYCLES edges after its opposite fell. Float shutdown appears on the edge that takes the HOLDOFF_CYCLES-th consecutive mid sample. The bench steps its reference model on each rising edge, using the inputs that were stable across that edge. It compares all four outputs at the following falling edge and changes inputs only after that comparison, so each result is checked in exactly the cycle it is due.

// File: rtl/gdc_pkg.sv
`timescale 1ns/1ps
package gdc_pkg;

  // three-level digitized input codes
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSV  = 2'b11
  } lvl_e;

  // reported operating mode, lower code wins
  typedef enum logic [1:0] {
    MODE_LOCK = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_FLT  = 2'b10,
    MODE_RUN  = 2'b11
  } mode_e;

  // gate requested by the mode logic
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_HS   = 2'b01,
    REQ_LS   = 2'b10
  } gate_req_e;

endpackage

// File: rtl/gdc_rst_sync.sv
`timescale 1ns/1ps
module gdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/gdc_uvlo.sv
`timescale 1ns/1ps
module gdc_uvlo (
  input  logic clk,
  input  logic rst_n,
  input  logic above_start,
  input  logic below_stop,
  output logic locked
);

  logic lock_q;
  logic lock_d;

  // hysteresis: leave on the start flag, return on the stop flag
  always_comb begin
    lock_d = lock_q;
    if (lock_q) begin
      if (above_start && !below_stop) lock_d = 1'b0;
    end else if (below_stop) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_d;
  end

  assign locked = lock_q;

endmodule

// File: rtl/gdc_float_det.sv
`timescale 1ns/1ps
module gdc_float_det
  import gdc_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_clr,
  input  logic [1:0] pwm_lvl,
  output logic       flt_latched,
  output logic       dir_high
);

  localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;
  logic          dir_q, dir_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    flt_d  = flt_q;
    dir_d  = dir_q;
    cnt_en = 1'b0;
    case (pwm_lvl)
      LVL_HIGH: begin
        dir_d  = 1'b1;
        flt_d  = 1'b0;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      LVL_LOW: begin
        dir_d  = 1'b0;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      default: begin
        if (cnt_q == LAST) begin
          flt_d = 1'b1;
        end else begin
          cnt_d  = cnt_q + CW'(1);
          cnt_en = 1'b1;
        end
      end
    endcase
    if (hold_clr) begin
      cnt_d  = '0;
      flt_d  = 1'b0;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flt_q <= flt_d;
      dir_q <= dir_d;
    end
  end

  assign flt_latched = flt_q;
  assign dir_high    = dir_q;

endmodule

// File: rtl/gdc_overlap.sv
`timescale 1ns/1ps
module gdc_overlap
  import gdc_pkg::*;
#(
  parameter int DEAD_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  gate_req_e req,
  output logic      hs_on,
  output logic      ls_on
);

  localparam int GW = $clog2(DEAD_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CYCLES);

  logic          hs_q, hs_d;
  logic          ls_q, ls_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          gap_en;

  always_comb begin
    hs_d   = hs_q;
    ls_d   = ls_q;
    gap_d  = gap_q;
    gap_en = 1'b0;
    if ((hs_q && req != REQ_HS) || (ls_q && req != REQ_LS)) begin
      hs_d   = 1'b0;
      ls_d   = 1'b0;
      gap_d  = GW'(1);
      gap_en = 1'b1;
    end else if (!hs_q && !ls_q) begin
      if (req != REQ_NONE && gap_q >= GAP_MAX) begin
        hs_d = (req == REQ_HS);
        ls_d = (req == REQ_LS);
      end else if (gap_q != GAP_MAX) begin
        gap_d  = gap_q + GW'(1);
        gap_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      if (gap_en) gap_q <= gap_d;
    end
  end

  assign hs_on = hs_q;
  assign ls_on = ls_q;

endmodule

// File: rtl/gate_drive_ctrl.sv
`timescale 1ns/1ps
module gate_drive_ctrl
  import gdc_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 24,
  parameter int DEAD_CYCLES    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic [1:0] en_lvl,
  input  logic       uv_start,
  input  logic       uv_stop,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic       reg_en,
  output logic [1:0] mode
);

  logic      rst_i_n;
  logic      locked;
  logic      flt;
  logic      dir_high;
  logic      en_q;
  mode_e     mode_s;
  gate_req_e req_s;

  gdc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  gdc_uvlo u_uvlo (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .above_start (uv_start),
    .below_stop  (uv_stop),
    .locked      (locked)
  );

  gdc_float_det #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_flt (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .hold_clr    (locked),
    .pwm_lvl     (pwm_lvl),
    .flt_latched (flt),
    .dir_high    (dir_high)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) en_q <= 1'b0;
    else          en_q <= (en_lvl == LVL_HIGH);
  end

  always_comb begin
    if (locked)     mode_s = MODE_LOCK;
    else if (!en_q) mode_s = MODE_OFF;
    else if (flt)   mode_s = MODE_FLT;
    else            mode_s = MODE_RUN;
  end

  always_comb begin
    if (mode_s != MODE_RUN) req_s = REQ_NONE;
    else if (dir_high)      req_s = REQ_HS;
    else                    req_s = REQ_LS;
  end

  gdc_overlap #(.DEAD_CYCLES(DEAD_CYCLES)) u_ovl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .req   (req_s),
    .hs_on (hs_gate),
    .ls_on (ls_gate)
  );

  assign reg_en = !locked;
  assign mode   = mode_s;

endmodule

// File: rtl/gdc_checker.sv
`timescale 1ns/1ps
module gdc_checker #(
  parameter int DEAD_CYCLES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwm_lvl,
  input logic       uv_start,
  input logic       uv_stop,
  input logic       hs_gate,
  input logic       ls_gate,
  input logic       reg_en,
  input logic [1:0] mode
);

  localparam int ZW = $clog2(DEAD_CYCLES + 1) + 1;
  localparam logic [ZW-1:0] ZMAX = ZW'(DEAD_CYCLES);

  logic [ZW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idle_q <= '0;
    else if (hs_gate || ls_gate)  idle_q <= '0;
    else if (idle_q != ZMAX)      idle_q <= idle_q + ZW'(1);
  end

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r7_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate) || $rose(ls_gate)) |-> (idle_q >= ZMAX));

  a_r10_gates_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |=> (!hs_gate && !ls_gate));

  a_r5_exit_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> $past(uv_start));

  a_r5_enter_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en) |-> $past(uv_stop));

  a_r3_float_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && pwm_lvl != 2'b10) |=> (mode != 2'b11));

endmodule

bind gate_drive_ctrl gdc_checker #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_lvl  (pwm_lvl),
  .uv_start (uv_start),
  .uv_stop  (uv_stop),
  .hs_gate  (hs_gate),
  .ls_gate  (ls_gate),
  .reg_en   (reg_en),
  .mode     (mode)
);

// File: tb/gate_drive_ctrl_bench.sv
`timescale 1ns/1ps
module gate_drive_ctrl_bench;

  localparam int HOLD = 24;
  localparam int DEAD = 3;

  logic       clk;
  logic       rst_n;
  logic [1:0] pwm_lvl;
  logic [1:0] en_lvl;
  logic       uv_start;
  logic       uv_stop;
  logic       hs_gate;
  logic       ls_gate;
  logic       reg_en;
  logic [1:0] mode;

  int checks;
  int errors;
  string cur_req;

  // reference model state
  int m_lock, m_en, m_flt, m_cnt, m_dir, m_hs, m_ls, m_gap;

  gate_drive_ctrl #(.HOLDOFF_CYCLES(HOLD), .DEAD_CYCLES(DEAD)) u_gate_drive_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_lvl  (pwm_lvl),
    .en_lvl   (en_lvl),
    .uv_start (uv_start),
    .uv_stop  (uv_stop),
    .hs_gate  (hs_gate),
    .ls_gate  (ls_gate),
    .reg_en   (reg_en),
    .mode     (mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_val(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lock = 1; m_en = 0; m_flt = 0; m_cnt = 0;
    m_dir = 0; m_hs = 0; m_ls = 0; m_gap = DEAD;
  endtask

  function automatic int model_mode();
    if (m_lock != 0) return 0;
    if (m_en == 0)   return 1;
    if (m_flt != 0)  return 2;
    return 3;
  endfunction

  task automatic model_step();
    int n_lock, n_en, n_flt, n_cnt, n_dir, n_hs, n_ls, n_gap, want;
    n_lock = m_lock; n_flt = m_flt; n_cnt = m_cnt; n_dir = m_dir;
    n_hs = m_hs; n_ls = m_ls; n_gap = m_gap;
    if (m_lock != 0) begin
      if (uv_start && !uv_stop) n_lock = 0;
    end else if (uv_stop) n_lock = 1;
    n_en = (en_lvl == 2'b10) ? 1 : 0;
    if (pwm_lvl == 2'b10) begin
      n_dir = 1; n_flt = 0; n_cnt = 0;
    end else if (pwm_lvl == 2'b00) begin
      n_dir = 0; n_cnt = 0;
    end else begin
      n_cnt = m_cnt + 1;
      if (n_cnt >= HOLD) begin n_flt = 1; n_cnt = HOLD; end
    end
    if (m_lock != 0) begin n_flt = 0; n_cnt = 0; end
    // want: 0 none, 1 high side, 2 low side
    want = (model_mode() == 3) ? ((m_dir != 0) ? 1 : 2) : 0;
    if ((m_hs != 0 && want != 1) || (m_ls != 0 && want != 2)) begin
      n_hs = 0; n_ls = 0; n_gap = 1;
    end else if (m_hs == 0 && m_ls == 0) begin
      if (want != 0 && m_gap >= DEAD) begin
        n_hs = (want == 1) ? 1 : 0;
        n_ls = (want == 2) ? 1 : 0;
      end else if (m_gap < DEAD) n_gap = m_gap + 1;
    end
    m_lock = n_lock; m_en = n_en; m_flt = n_flt; m_cnt = n_cnt;
    m_dir = n_dir; m_hs = n_hs; m_ls = n_ls; m_gap = n_gap;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_val("hs_gate", int'(hs_gate), m_hs);
    check_val("ls_gate", int'(ls_gate), m_ls);
    check_val("reg_en", int'(reg_en), (m_lock != 0) ? 0 : 1);
    check_val("mode", int'(mode), model_mode());
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0;
    cur_req = "R9";
    rst_n = 1'b0; pwm_lvl = 2'b00; en_lvl = 2'b10;
    uv_start = 1'b0; uv_stop = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check_val("hs_gate", int'(hs_gate), 0);
    check_val("ls_gate", int'(ls_gate), 0);
    check_val("reg_en", int'(reg_en), 0);
    check_val("mode", int'(mode), 0);
    rst_n = 1'b1;

    cur_req = "R6"; run(10);
    // R5: a single start pulse leaves lockout; low side comes on after the gap
    cur_req = "R5"; uv_start = 1'b1; tick(); uv_start = 1'b0; run(6);
    // R1 and R7: switching with dead time
    cur_req = "R1";
    pwm_lvl = 2'b10; run(8);
    pwm_lvl = 2'b00; run(8);
    pwm_lvl = 2'b10; run(8);
    // R2: mid runs one short of the hold-off do not shut down
    cur_req = "R2";
    pwm_lvl = 2'b01; run(HOLD - 1);
    pwm_lvl = 2'b00; run(8);
    pwm_lvl = 2'b11; run(HOLD - 1);
    pwm_lvl = 2'b10; run(8);
    pwm_lvl = 2'b01; run(HOLD + 6);
    // R3: low does not release, high does
    cur_req = "R3";
    pwm_lvl = 2'b00; run(10);
    pwm_lvl = 2'b01; run(10);
    pwm_lvl = 2'b10; run(10);
    // R4: every code except high disables switching, regulator stays on
    cur_req = "R4";
    en_lvl = 2'b00; pwm_lvl = 2'b00; run(6);
    en_lvl = 2'b01; pwm_lvl = 2'b10; run(6);
    en_lvl = 2'b11; run(6);
    en_lvl = 2'b10; run(8);
    // R8: disabled outranks float shutdown, which shows once enabled
    cur_req = "R8";
    en_lvl = 2'b00; pwm_lvl = 2'b01; run(HOLD + 4);
    en_lvl = 2'b10; run(6);
    pwm_lvl = 2'b00; run(8);
    // R5: stop flag locks out, both flags keep lockout, start alone exits
    cur_req = "R5";
    uv_stop = 1'b1; tick(); uv_stop = 1'b0; run(5);
    uv_start = 1'b1; uv_stop = 1'b1; run(3);
    uv_stop = 1'b0; run(6);
    uv_start = 1'b0; run(6);
    // R9: asynchronous reset in the middle of switching
    cur_req = "R9";
    pwm_lvl = 2'b10; run(8);
    #2 rst_n = 1'b0;
    #1;
    check_val("hs_gate", int'(hs_gate), 0);
    check_val("ls_gate", int'(ls_gate), 0);
    check_val("reg_en", int'(reg_en), 0);
    check_val("mode", int'(mode), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    run(10);
    cur_req = "R10"; uv_start = 1'b1; tick(); uv_start = 1'b0; run(8);
    pwm_lvl = 2'b00; run(8);
    finish_run();
  end

endmodule